// File: doc/BRIEF.md
# Byte-Stream Command Bridge to a Wishbone Master

This block turns a stream of bytes, as delivered by a serial receiver, into single 32-bit bus cycles on a classic Wishbone master port. Bytes arrive and leave on valid/ready streams. The serial line itself is handled elsewhere. Any byte whose upper nibble is zero that arrives at a command boundary is a one-byte synchronisation command. The block answers it with a fixed four-byte signature. Every other command is five bytes long and is sent most significant byte first. Its opcode is the upper nibble of the first byte, and bits 31:0 are carried in the last four bytes.

A bus access is split into separate commands. One command loads an internal 32-bit data register. A second command runs a read or a write cycle with that register. A third command sends the register back as four bytes. A further command loads a 32-bit auxiliary control output. The bridge accepts no input byte while a bus cycle is open or while a reply is still being sent. A slave that never acknowledges is cut off after a fixed number of cycles, and the read result is then all ones.

Top module: `bwb_bridge`

## Requirements
- R1: After reset the bus is idle (wb_cyc low), no reply byte is pending, aux_out is zero, in_ready is high, and a fetch command returns 0x00000000.
- R2: A first byte whose bits 7:4 are 0 is a complete command on its own. It is answered with the bytes 0xCA, 0xFE, 0xBA, 0xBE in that order, and the next byte starts a new command.
- R3: Opcode 2 loads bits 31:0 into the data register. Opcode 3 returns that register as four bytes, bits 31:24 first.
- R4: Opcode 4 drives bits 31:0 onto aux_out from the cycle after its last byte. Bits 35:32 of a command have no effect.
- R5: Opcode 1 with bit 20 clear runs one write cycle: wb_cyc and wb_stb high, wb_we high, wb_sel all ones, wb_dat_w equal to the data register. The cycle ends in the cycle where wb_ack is high.
- R6: Opcode 1 with bit 20 set runs one read cycle with wb_we low. The wb_dat_r value present with wb_ack is stored in the data register.
- R7: A cycle that gets no ack is dropped after exactly TIMEOUT cycles with wb_cyc high. A read that ends this way stores 0xFFFFFFFF.
- R8: in_ready is low whenever wb_cyc or out_valid is high.
- R9: Opcodes 5 to 15 start no bus cycle, send no reply, and change neither aux_out nor the data register.
- R10: While out_valid is high and out_ready is low, out_valid stays high and out_data does not change.
- R11: wb_adr equals bits 19:0 of the access command. Bits 35:21 do not affect the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_data | input | 8 | Received command byte |
| in_valid | input | 1 | in_data holds a byte |
| in_ready | output | 1 | Bridge takes the byte this cycle |
| out_data | output | 8 | Reply byte |
| out_valid | output | 1 | out_data holds a byte |
| out_ready | input | 1 | Consumer takes the reply byte |
| wb_cyc | output | 1 | Bus cycle in progress |
| wb_stb | output | 1 | Strobe |
| wb_we | output | 1 | Write enable |
| wb_adr | output | ADDR_W | Word address |
| wb_dat_w | output | 32 | Write data |
| wb_sel | output | 4 | Byte selects, all ones |
| wb_dat_r | input | 32 | Read data |
| wb_ack | input | 1 | Cycle acknowledge |
| aux_out | output | 32 | Auxiliary control word |

## Verification
The bench builds the bridge with TIMEOUT set to 8 and keeps ADDR_W at 20. The short timeout lets the slave's ack delay be swept from zero past the abort point. Each read and write can then be checked on both sides of the boundary, including the case where the ack would arrive one cycle too late. The slave model stores 16 words selected by the low address bits. Every word is written and read back with high address bits and ignored command bits set. Reply streams are also run with a toggling out_ready to exercise stalls.

// File: rtl/bwb_pkg.sv
package bwb_pkg;
    localparam int DATA_W      = 32;
    localparam int RD_FLAG_BIT = 20;
    localparam logic [31:0] SYNC_REPLY = 32'hCAFE_BABE;

    typedef enum logic [3:0] {
        OP_SYNC   = 4'd0,
        OP_ACCESS = 4'd1,
        OP_LOAD   = 4'd2,
        OP_FETCH  = 4'd3,
        OP_AUX    = 4'd4
    } opcode_e;

    // Parser state: byte index, latched opcode, bytes 2..4 of the body,
    // data register and auxiliary register.
    typedef struct packed {
        logic [2:0]        idx;
        logic [3:0]        op;
        logic [23:0]       body;
        logic [DATA_W-1:0] data;
        logic [DATA_W-1:0] aux;
    } parse_s;
endpackage

// File: rtl/bwb_reply_tx.sv
module bwb_reply_tx #(
    parameter int NBYTES = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load_i,
    input  logic [8*NBYTES-1:0] word_i,
    output logic [7:0]          out_data_o,
    output logic                out_valid_o,
    input  logic                out_ready_i,
    output logic                busy_o
);
    localparam int W  = 8 * NBYTES;
    localparam int CW = $clog2(NBYTES + 1);

    typedef struct packed {
        logic [CW-1:0] left;
        logic [W-1:0]  sh;
    } tx_s;

    tx_s q, d;

    always_comb begin
        d = q;
        if (load_i) begin
            d.left = CW'(NBYTES);
            d.sh   = word_i;
        end else if (q.left != '0 && out_ready_i) begin
            d.sh   = q.sh << 8;
            d.left = q.left - CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign out_data_o  = q.sh[W-1 -: 8];
    assign out_valid_o = (q.left != '0);
    assign busy_o      = out_valid_o;
endmodule

// File: rtl/bwb_wb_master.sv
module bwb_wb_master #(
    parameter int ADDR_W  = 20,
    parameter int DATA_W  = 32,
    parameter int TIMEOUT = 256
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic                we_i,
    input  logic [ADDR_W-1:0]   adr_i,
    input  logic [DATA_W-1:0]   dat_i,
    output logic                wb_cyc_o,
    output logic                wb_stb_o,
    output logic                wb_we_o,
    output logic [ADDR_W-1:0]   wb_adr_o,
    output logic [DATA_W-1:0]   wb_dat_o,
    output logic [DATA_W/8-1:0] wb_sel_o,
    input  logic [DATA_W-1:0]   wb_dat_i,
    input  logic                wb_ack_i,
    output logic                busy_o,
    output logic                rd_done_o,
    output logic [DATA_W-1:0]   rd_data_o
);
    localparam int CW = (TIMEOUT > 1) ? $clog2(TIMEOUT) : 1;

    typedef struct packed {
        logic              cyc;
        logic              we;
        logic [ADDR_W-1:0] adr;
        logic [DATA_W-1:0] wdat;
        logic [CW-1:0]     wait_cnt;
        logic              rd_done;
        logic [DATA_W-1:0] rdat;
    } bus_s;

    bus_s q, d;

    always_comb begin
        d         = q;
        d.rd_done = 1'b0;
        if (q.cyc) begin
            if (wb_ack_i) begin
                d.cyc     = 1'b0;
                d.rd_done = !q.we;
                d.rdat    = wb_dat_i;
            end else if (q.wait_cnt == CW'(TIMEOUT - 1)) begin
                d.cyc     = 1'b0;
                d.rd_done = !q.we;
                d.rdat    = '1;
            end else begin
                d.wait_cnt = q.wait_cnt + CW'(1);
            end
        end else if (start_i) begin
            d.cyc      = 1'b1;
            d.we       = we_i;
            d.adr      = adr_i;
            d.wdat     = dat_i;
            d.wait_cnt = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign wb_cyc_o  = q.cyc;
    assign wb_stb_o  = q.cyc;
    assign wb_we_o   = q.we;
    assign wb_adr_o  = q.adr;
    assign wb_dat_o  = q.wdat;
    assign wb_sel_o  = '1;
    assign busy_o    = q.cyc;
    assign rd_done_o = q.rd_done;
    assign rd_data_o = q.rdat;
endmodule

// File: rtl/bwb_bridge.sv
module bwb_bridge
    import bwb_pkg::*;
#(
    parameter int ADDR_W  = 20,
    parameter int TIMEOUT = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        in_data,
    input  logic              in_valid,
    output logic              in_ready,
    output logic [7:0]        out_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic              wb_cyc,
    output logic              wb_stb,
    output logic              wb_we,
    output logic [ADDR_W-1:0] wb_adr,
    output logic [31:0]       wb_dat_w,
    output logic [3:0]        wb_sel,
    input  logic [31:0]       wb_dat_r,
    input  logic              wb_ack,
    output logic [31:0]       aux_out
);
    localparam logic [2:0] LAST_IDX = 3'd4;

    parse_s q, d;

    logic              bus_busy, tx_busy, rd_done;
    logic [31:0]       rd_data;
    logic              start, start_we;
    logic              tx_load;
    logic [31:0]       tx_word;
    logic              take;
    logic [31:0]       word;

    assign in_ready = !bus_busy && !tx_busy;
    assign take     = in_valid && in_ready;
    assign word     = {q.body, in_data};

    always_comb begin
        d        = q;
        start    = 1'b0;
        start_we = 1'b0;
        tx_load  = 1'b0;
        tx_word  = q.data;
        if (rd_done) d.data = rd_data;
        if (take) begin
            if (q.idx == 3'd0) begin
                if (in_data[7:4] == OP_SYNC) begin
                    tx_load = 1'b1;
                    tx_word = SYNC_REPLY;
                end else begin
                    d.op  = in_data[7:4];
                    d.idx = 3'd1;
                end
            end else if (q.idx != LAST_IDX) begin
                d.body = {q.body[15:0], in_data};
                d.idx  = q.idx + 3'd1;
            end else begin
                d.idx = 3'd0;
                case (q.op)
                    OP_LOAD:   d.data = word;
                    OP_AUX:    d.aux  = word;
                    OP_FETCH:  tx_load = 1'b1;
                    OP_ACCESS: begin
                        start    = 1'b1;
                        start_we = !word[RD_FLAG_BIT];
                    end
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign aux_out = q.aux;

    bwb_wb_master #(
        .ADDR_W (ADDR_W),
        .DATA_W (32),
        .TIMEOUT(TIMEOUT)
    ) u_bus (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start),
        .we_i     (start_we),
        .adr_i    (word[ADDR_W-1:0]),
        .dat_i    (q.data),
        .wb_cyc_o (wb_cyc),
        .wb_stb_o (wb_stb),
        .wb_we_o  (wb_we),
        .wb_adr_o (wb_adr),
        .wb_dat_o (wb_dat_w),
        .wb_sel_o (wb_sel),
        .wb_dat_i (wb_dat_r),
        .wb_ack_i (wb_ack),
        .busy_o   (bus_busy),
        .rd_done_o(rd_done),
        .rd_data_o(rd_data)
    );

    bwb_reply_tx #(.NBYTES(4)) u_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tx_load),
        .word_i     (tx_word),
        .out_data_o (out_data),
        .out_valid_o(out_valid),
        .out_ready_i(out_ready),
        .busy_o     (tx_busy)
    );
endmodule

// File: rtl/bwb_bridge_chk.sv
module bwb_bridge_chk #(
    parameter int ADDR_W  = 20,
    parameter int TIMEOUT = 256
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_ready,
    input logic [7:0]        out_data,
    input logic              out_valid,
    input logic              out_ready,
    input logic              wb_cyc,
    input logic              wb_we,
    input logic [ADDR_W-1:0] wb_adr,
    input logic [31:0]       wb_dat_w,
    input logic              wb_ack
);
    localparam int CW = $clog2(TIMEOUT + 1);

    logic [CW-1:0] open_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)      open_cnt <= '0;
        else if (wb_cyc) open_cnt <= open_cnt + CW'(1);
        else             open_cnt <= '0;
    end

    p_ready_bus_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wb_cyc |-> !in_ready);

    p_ready_tx_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready);

    p_out_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    p_ack_ends_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_cyc && wb_ack) |=> !wb_cyc);

    p_bus_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_cyc && !wb_ack) |=> (!wb_cyc ||
            ($stable(wb_adr) && $stable(wb_we) && $stable(wb_dat_w))));

    p_timeout_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wb_cyc |-> (open_cnt < CW'(TIMEOUT)));
endmodule

bind bwb_bridge bwb_bridge_chk #(.ADDR_W(ADDR_W), .TIMEOUT(TIMEOUT)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_ready (in_ready),
    .out_data (out_data),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .wb_cyc   (wb_cyc),
    .wb_we    (wb_we),
    .wb_adr   (wb_adr),
    .wb_dat_w (wb_dat_w),
    .wb_ack   (wb_ack)
);

// File: tb/bwb_bridge_test.sv
module bwb_bridge_test;
    localparam int TO = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  in_data = '0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [7:0]  out_data;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic        wb_cyc, wb_stb, wb_we;
    logic [19:0] wb_adr;
    logic [31:0] wb_dat_w, wb_dat_r;
    logic [3:0]  wb_sel;
    logic        wb_ack = 1'b0;
    logic [31:0] aux_out;

    always #2.5 clk = ~clk;

    bwb_bridge #(.ADDR_W(20), .TIMEOUT(TO)) uut (
        .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid),
        .in_ready(in_ready), .out_data(out_data), .out_valid(out_valid),
        .out_ready(out_ready), .wb_cyc(wb_cyc), .wb_stb(wb_stb), .wb_we(wb_we),
        .wb_adr(wb_adr), .wb_dat_w(wb_dat_w), .wb_sel(wb_sel),
        .wb_dat_r(wb_dat_r), .wb_ack(wb_ack), .aux_out(aux_out)
    );

    int checks = 0;
    int errs = 0;
    bit finished = 0;

    // slave model
    logic [31:0] mem [16];
    int ack_delay = 0;
    int dcnt = 0;
    assign wb_dat_r = mem[wb_adr[3:0]];

    always @(posedge clk) begin
        if (wb_cyc && !wb_ack) begin
            if (dcnt == ack_delay) wb_ack <= 1'b1;
            dcnt <= dcnt + 1;
        end else begin
            wb_ack <= 1'b0;
            dcnt   <= 0;
        end
        if (wb_cyc && wb_ack && wb_we) mem[wb_adr[3:0]] <= wb_dat_w;
    end

    // observers, sampled at the falling edge
    bit          bp = 0;
    int          tick = 0;
    logic [7:0]  rx_buf [64];
    int          rx_cnt = 0;
    int          viol_ready = 0, viol_hold = 0;
    bit          prev_stall = 0;
    logic [7:0]  prev_byte = '0;
    int          run = 0, last_len = 0, cyc_starts = 0;
    logic [19:0] last_adr = '0;
    logic        last_we = 1'b0;
    logic [31:0] last_dat = '0;

    always @(negedge clk) begin
        tick = tick + 1;
        out_ready = bp ? tick[1] : 1'b1;
        if (rst_n) begin
            if ((wb_cyc || out_valid) && in_ready) viol_ready++;
            if (prev_stall && (!out_valid || out_data != prev_byte)) viol_hold++;
            prev_stall = out_valid && !out_ready;
            prev_byte  = out_data;
            if (out_valid && out_ready) begin
                rx_buf[rx_cnt % 64] = out_data;
                rx_cnt++;
            end
            if (wb_cyc) begin
                if (run == 0) begin
                    cyc_starts++;
                    last_adr = wb_adr;
                    last_we  = wb_we;
                    last_dat = wb_dat_w;
                end
                run++;
            end else if (run != 0) begin
                last_len = run;
                run = 0;
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errs++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic send_byte(input logic [7:0] b);
        @(negedge clk);
        in_data  = b;
        in_valid = 1'b1;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic send_cmd(input logic [3:0] op, input logic [35:0] body);
        send_byte({op, body[35:32]});
        send_byte(body[31:24]);
        send_byte(body[23:16]);
        send_byte(body[15:8]);
        send_byte(body[7:0]);
    endtask

    task automatic settle();
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic reply_word(input int base, output logic [31:0] w, output int n);
        n = rx_cnt - base;
        w = {rx_buf[base % 64], rx_buf[(base + 1) % 64],
             rx_buf[(base + 2) % 64], rx_buf[(base + 3) % 64]};
    endtask

    task automatic fetch(input string tag, input logic [31:0] exp);
        int base, n;
        logic [31:0] w;
        base = rx_cnt;
        send_cmd(4'd3, 36'h0);
        settle();
        reply_word(base, w, n);
        chk({tag, " count"}, 32'(n), 32'd4);
        chk(tag, w, exp);
    endtask

    function automatic logic [31:0] pat(input int a);
        return 32'hA500_0000 | (32'(a) * 32'h0001_0101) ^ 32'h0000_3C00;
    endfunction

    function automatic logic [19:0] adr_of(input int a);
        return {16'(a * 16'h0123 + 16'h0040), 4'(a)};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errs++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        int base, n;
        logic [31:0] w, v;
        logic [3:0]  junk;
        for (int i = 0; i < 16; i++) mem[i] = 32'h0;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk("R1 wb_cyc", 32'(wb_cyc), 32'd0);
        chk("R1 out_valid", 32'(out_valid), 32'd0);
        chk("R1 aux_out", aux_out, 32'd0);
        chk("R1 in_ready", 32'(in_ready), 32'd1);
        fetch("R1 data reg", 32'h0);

        // R2: sync bytes with zero upper nibble
        for (int k = 0; k < 3; k++) begin
            base = rx_cnt;
            send_byte(k == 0 ? 8'h00 : (k == 1 ? 8'h05 : 8'h0F));
            settle();
            reply_word(base, w, n);
            chk("R2 count", 32'(n), 32'd4);
            chk("R2 signature", w, 32'hCAFEBABE);
        end
        // R2: command right after sync parses from its first byte
        send_byte(8'h00);
        settle();
        send_cmd(4'd2, {4'h0, 32'h0BAD_F00D});
        fetch("R2 fresh start", 32'h0BAD_F00D);

        // R3: load then fetch, MSB first
        for (int i = 0; i < 8; i++) begin
            v = (32'h1357_9BDF * 32'(i + 1)) ^ (32'(i) << 28);
            send_cmd(4'd2, {4'(i + 3), v});
            fetch("R3 load/fetch", v);
        end

        // R4: auxiliary register, high bits ignored
        for (int i = 0; i < 6; i++) begin
            v = 32'hF0E1_D2C3 ^ (32'(i) * 32'h1111_0001);
            send_cmd(4'd4, {4'(15 - i), v});
            settle();
            chk("R4 aux_out", aux_out, v);
        end

        // R5/R11: writes, every slave word, high command bits set
        ack_delay = 0;
        for (int a = 0; a < 16; a++) begin
            n = cyc_starts;
            send_cmd(4'd2, {4'h0, pat(a)});
            junk = 4'(a);
            send_cmd(4'd1, {junk, 11'h5AA, 1'b0, adr_of(a)});
            settle();
            chk("R5 one cycle", 32'(cyc_starts - n), 32'd1);
            chk("R5 we", 32'(last_we), 32'd1);
            chk("R5 wdata", last_dat, pat(a));
            chk("R5 length", 32'(last_len), 32'd2);
            chk("R11 address", 32'(last_adr), 32'(adr_of(a)));
            chk("R5 slave word", mem[a], pat(a));
        end
        chk("R5 sel", 32'(wb_sel), 32'hF);

        // R6: reads with varying ack delay
        for (int a = 0; a < 16; a++) begin
            send_cmd(4'd2, {4'h0, 32'h0});
            ack_delay = a % (TO - 1);
            send_cmd(4'd1, {4'hC, 11'h7FF, 1'b1, adr_of(a)});
            settle();
            chk("R6 we", 32'(last_we), 32'd0);
            chk("R6 length", 32'(last_len), 32'(ack_delay + 2));
            chk("R11 read address", 32'(last_adr), 32'(adr_of(a)));
            fetch("R6 read data", pat(a));
        end

        // R7: sweep ack delay across the abort point
        for (int dl = 0; dl < TO + 2; dl++) begin
            ack_delay = dl;
            send_cmd(4'd1, {4'h0, 11'h0, 1'b1, adr_of(3)});
            settle();
            chk("R7 length", 32'(last_len), (dl <= TO - 2) ? 32'(dl + 2) : 32'(TO));
            fetch("R7 read result", (dl <= TO - 2) ? pat(3) : 32'hFFFF_FFFF);
        end
        // R7: unacknowledged write leaves the slave untouched
        ack_delay = 255;
        send_cmd(4'd2, {4'h0, 32'h1234_5678});
        send_cmd(4'd1, {4'h0, 11'h0, 1'b0, adr_of(9)});
        settle();
        chk("R7 write length", 32'(last_len), 32'(TO));
        chk("R7 write not stored", mem[9], pat(9));

        // R8: input blocked during an open cycle
        ack_delay = 5;
        send_cmd(4'd1, {4'h0, 11'h0, 1'b1, adr_of(2)});
        chk("R8 cyc open", 32'(wb_cyc), 32'd1);
        chk("R8 in_ready low", 32'(in_ready), 32'd0);
        settle();
        send_cmd(4'd2, {4'h0, 32'h1234_5678});

        // R9: unused opcodes
        ack_delay = 0;
        w = aux_out;
        for (int op = 5; op < 16; op++) begin
            n = cyc_starts;
            base = rx_cnt;
            send_cmd(4'(op), {4'h0, 32'hDEAD_0000 | 32'(op)});
            settle();
            chk("R9 aux kept", aux_out, w);
            chk("R9 no cycle", 32'(cyc_starts - n), 32'd0);
            chk("R9 no reply", 32'(rx_cnt - base), 32'd0);
        end
        fetch("R9 data kept", 32'h1234_5678);

        // R10: replies under back-pressure
        bp = 1;
        base = rx_cnt;
        send_byte(8'h00);
        settle();
        reply_word(base, w, n);
        chk("R10 sync stalled", w, 32'hCAFEBABE);
        send_cmd(4'd2, {4'h0, 32'h8001_7FFE});
        fetch("R10 fetch stalled", 32'h8001_7FFE);
        bp = 0;

        chk("R10 hold violations", 32'(viol_hold), 32'd0);
        chk("R8 ready violations", 32'(viol_ready), 32'd0);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule